// File: doc/BRIEF.md
# Switchable On-Chip RAM Window

This block places a small single-cycle memory behind a CPU bus with a 24-bit byte address and a 16-bit data path. A one-bit enable register selects where two fixed address ranges go. When the bit is set, those ranges reach the internal array. When it is clear, the same accesses are passed to an external-bus request port. The first range runs from a parameterized base up to 0xFFEFBF. The second covers the top 64 bytes of the address map, 0xFFFFC0 to 0xFFFFFF.

Bytes are stored big-endian on the 16-bit port. The byte at an even address sits in bits 15:8 and the byte at the next odd address sits in bits 7:0. There is a blocked region that starts at 0xFFB000 and ends one byte below the base. While the bit is set, reads of this region return all ones, writes to it change nothing, and either kind of access raises a one-cycle fault strobe. Every other address is always forwarded to the external port, unchanged and in the same cycle.

Internal accesses finish in one clock. A done pulse and any read data appear on the cycle after the request. Software changes the enable bit through a separate control strobe.

Top module: `ram_window`

## Requirements
- R1: With the enable bit at 1, a request in the main range (base up to 0xFFEFBF) goes to the internal array. extReq stays low and cpuDone pulses on the next cycle.
- R2: With the enable bit at 1, a request in the range 0xFFFFC0 to 0xFFFFFF goes to the internal array. This storage is separate from the main range.
- R3: With the enable bit at 0, a request to the main range, the upper range or the blocked region raises extReq in the same cycle. It produces no cpuDone, fault or misalign pulse.
- R4: For any request that is forwarded, extAddr, extWe, extWord and extWdata equal the CPU inputs in the same cycle. Addresses outside the three regions are always forwarded.
- R5: An internal or blocked access gives exactly one cpuDone pulse, on the cycle after the request. Read data on cpuRdata is valid in that cycle and holds until the next read completes.
- R6: A word read returns {byte at even address, byte at odd address}. A word write stores cpuWdata[15:8] to the even address and cpuWdata[7:0] to the odd address.
- R7: A byte write takes its data from cpuWdata[7:0] and stores it only in the addressed byte. The other byte of the same word is left unchanged.
- R8: A byte read returns {8'h00, addressed byte}.
- R9: A word access with address bit 0 set is handled as if bit 0 were 0. It pulses misalign for one cycle, on the cycle after the request.
- R10: With the enable bit at 1, a read of the blocked region (0xFFB000 to base-1) returns 16'hFFFF and pulses fault on the next cycle.
- R11: With the enable bit at 1, a write to the blocked region changes no stored byte and pulses fault on the next cycle.
- R12: The enable bit resets to 1. A write through ctlWe/ctlData takes effect from the next cycle onward. An access in the same cycle as the write is decoded with the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuReq | input | 1 | Access request, one cycle per access |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpuAddr | input | 24 | Byte address |
| cpuWdata | input | 16 | Write data (byte writes use bits 7:0) |
| ctlWe | input | 1 | Enable-bit write strobe |
| ctlData | input | 1 | New enable-bit value |
| cpuRdata | output | 16 | Read data, valid with cpuDone on reads |
| cpuDone | output | 1 | Internal or blocked access completed |
| misalign | output | 1 | Odd-address word access seen |
| fault | output | 1 | Blocked-region access seen |
| extReq | output | 1 | Request forwarded to the external bus |
| extWe | output | 1 | Forwarded write flag |
| extWord | output | 1 | Forwarded size flag |
| extAddr | output | 24 | Forwarded address |
| extWdata | output | 16 | Forwarded write data |

## Verification
The bound checker recomputes the region decode on its own. On every cycle it checks the following:
- enabled accesses to either range never reach the external port and always finish one cycle later;
- with the bit clear, every windowed access is forwarded and produces no completion;
- odd word accesses and blocked reads raise their flags, and blocked reads return all ones;
- the enable bit follows each control write.

Byte-lane placement, the preservation of the untouched byte, the separation of the two ranges and the fact that blocked or forwarded writes leave storage intact depend on stored contents. Only the bench's reference model can show these, by reading the data back after the scenarios.

// File: rtl/ram_window_pkg.sv
package ram_window_pkg;

  // Strobes from the control/decode side to the datapath for one access
  typedef struct packed {
    logic memRd;    // read the array
    logic wrHi;     // write bits 15:8
    logic wrLo;     // write bits 7:0
    logic isWord;   // word access
    logic laneLo;   // byte access targets bits 7:0
    logic faultRd;  // blocked-region read
    logic faultHit; // blocked-region access of either kind
    logic misHit;   // odd word address
  } ramStrobe_t;

  localparam logic [23:0] RSV_START = 24'hFFB000;
  localparam logic [23:0] MAIN_LAST = 24'hFFEFBF;
  localparam logic [23:0] TOP_START = 24'hFFFFC0;

endpackage

// File: rtl/ram_window_ctrl.sv
module ram_window_ctrl
  import ram_window_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter logic [23:0] BASE_ADDR = 24'hFFE000,
  parameter int          IDX_W     = 11,
  parameter int          MAIN_WORDS = 2016
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuWord,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              ctlWe,
  input  logic              ctlData,
  output logic              ramEn,
  output logic              extReq,
  output ramStrobe_t        strobe,
  output logic [IDX_W-1:0]  wordIdx
);

  logic inMain, inTop, inRsv, hitRam, hitRsv;
  logic [ADDR_W-1:0] mainOff, topOff, idxFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ramEn <= 1'b1;
    else if (ctlWe) ramEn <= ctlData;
  end

  always_comb begin
    inMain = (cpuAddr >= ADDR_W'(BASE_ADDR)) && (cpuAddr <= ADDR_W'(MAIN_LAST));
    inTop  = (cpuAddr >= ADDR_W'(TOP_START));
    inRsv  = (cpuAddr >= ADDR_W'(RSV_START)) && (cpuAddr < ADDR_W'(BASE_ADDR));
    hitRam = cpuReq && ramEn && (inMain || inTop);
    hitRsv = cpuReq && ramEn && inRsv;
    extReq = cpuReq && !hitRam && !hitRsv;
  end

  always_comb begin
    mainOff = cpuAddr - ADDR_W'(BASE_ADDR);
    topOff  = cpuAddr - ADDR_W'(TOP_START);
    if (inMain) idxFull = {1'b0, mainOff[ADDR_W-1:1]};
    else        idxFull = {1'b0, topOff[ADDR_W-1:1]} + ADDR_W'(MAIN_WORDS);
    wordIdx = idxFull[IDX_W-1:0];
  end

  always_comb begin
    strobe          = '0;
    strobe.isWord   = cpuWord;
    strobe.laneLo   = cpuAddr[0];
    strobe.memRd    = hitRam && !cpuWe;
    strobe.wrHi     = hitRam && cpuWe && (cpuWord || !cpuAddr[0]);
    strobe.wrLo     = hitRam && cpuWe && (cpuWord || cpuAddr[0]);
    strobe.misHit   = hitRam && cpuWord && cpuAddr[0];
    strobe.faultHit = hitRsv;
    strobe.faultRd  = hitRsv && !cpuWe;
  end

endmodule

// File: rtl/ram_window_dp.sv
module ram_window_dp
  import ram_window_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WORDS  = 2048,
  parameter int IDX_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              misalign,
  output logic              fault
);

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] mem [WORDS];
  logic [HALF-1:0]   hiByte, loByte, pickByte;
  logic [DATA_W-1:0] curWord;

  always_comb begin
    hiByte   = strobe.isWord ? wdata[DATA_W-1:HALF] : wdata[HALF-1:0];
    loByte   = wdata[HALF-1:0];
    curWord  = mem[wordIdx];
    pickByte = strobe.laneLo ? curWord[HALF-1:0] : curWord[DATA_W-1:HALF];
  end

  always_ff @(posedge clk) begin
    if (strobe.wrHi) mem[wordIdx][DATA_W-1:HALF] <= hiByte;
    if (strobe.wrLo) mem[wordIdx][HALF-1:0]      <= loByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata    <= '0;
      done     <= 1'b0;
      misalign <= 1'b0;
      fault    <= 1'b0;
    end else begin
      done     <= strobe.memRd || strobe.wrHi || strobe.wrLo || strobe.faultHit;
      misalign <= strobe.misHit;
      fault    <= strobe.faultHit;
      if (strobe.faultRd)     rdata <= '1;
      else if (strobe.memRd)  rdata <= strobe.isWord ? curWord : {{HALF{1'b0}}, pickByte};
    end
  end

endmodule

// File: rtl/ram_window.sv
module ram_window
  import ram_window_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 16,
  parameter logic [23:0] BASE_ADDR = 24'hFFE000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic              cpuWord,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              ctlWe,
  input  logic              ctlData,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              misalign,
  output logic              fault,
  output logic              extReq,
  output logic              extWe,
  output logic              extWord,
  output logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata
);

  localparam int MAIN_WORDS = (int'(MAIN_LAST) + 1 - int'(BASE_ADDR)) / 2;
  localparam int TOP_WORDS  = (int'(24'hFFFFFF) + 1 - int'(TOP_START)) / 2;
  localparam int WORDS      = MAIN_WORDS + TOP_WORDS;
  localparam int IDX_W      = $clog2(WORDS);

  ramStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic             ramEn;

  ram_window_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W), .MAIN_WORDS(MAIN_WORDS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuWord(cpuWord),
    .cpuAddr(cpuAddr), .ctlWe(ctlWe), .ctlData(ctlData), .ramEn(ramEn),
    .extReq(extReq), .strobe(strobe), .wordIdx(wordIdx)
  );

  ram_window_dp #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIdx(wordIdx), .wdata(cpuWdata),
    .rdata(cpuRdata), .done(cpuDone), .misalign(misalign), .fault(fault)
  );

  assign extWe    = cpuWe;
  assign extWord  = cpuWord;
  assign extAddr  = cpuAddr;
  assign extWdata = cpuWdata;

endmodule

// File: rtl/ram_window_chk.sv
module ram_window_chk #(
  parameter logic [23:0] BASE_ADDR = 24'hFFE000
) (
  input logic        clk,
  input logic        rstN,
  input logic        ramEn,
  input logic        cpuReq,
  input logic        cpuWe,
  input logic        cpuWord,
  input logic [23:0] cpuAddr,
  input logic        ctlWe,
  input logic        ctlData,
  input logic        extReq,
  input logic        cpuDone,
  input logic [15:0] cpuRdata,
  input logic        misalign,
  input logic        fault
);

  logic mainHit, topHit, rsvHit;
  assign mainHit = cpuAddr >= BASE_ADDR && cpuAddr <= 24'hFFEFBF;
  assign topHit  = cpuAddr >= 24'hFFFFC0;
  assign rsvHit  = cpuAddr >= 24'hFFB000 && cpuAddr < BASE_ADDR;

  assert_main_internal_R1: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && ramEn && mainHit |-> !extReq ##1 cpuDone);

  assert_top_internal_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && ramEn && topHit |-> !extReq ##1 cpuDone);

  assert_off_forwards_R3: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && !ramEn && (mainHit || topHit || rsvHit) |-> extReq ##1 (!cpuDone && !fault && !misalign));

  assert_done_has_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |=> !cpuDone);

  assert_odd_word_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && ramEn && (mainHit || topHit) && cpuWord && cpuAddr[0] |=> misalign);

  assert_blocked_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && ramEn && rsvHit && !cpuWe |=> fault && cpuRdata == 16'hFFFF);

  assert_blocked_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && ramEn && rsvHit && cpuWe |-> !extReq ##1 fault);

  assert_enable_update_R12: assert property (@(posedge clk) disable iff (!rstN)
    ctlWe |=> ramEn == $past(ctlData));

endmodule

bind ram_window ram_window_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .ramEn(ramEn), .cpuReq(cpuReq), .cpuWe(cpuWe),
  .cpuWord(cpuWord), .cpuAddr(cpuAddr), .ctlWe(ctlWe), .ctlData(ctlData),
  .extReq(extReq), .cpuDone(cpuDone), .cpuRdata(cpuRdata),
  .misalign(misalign), .fault(fault)
);

// File: tb/ram_window_bench.sv
module ram_window_bench;

  localparam logic [23:0] BASE = 24'hFFE000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0, we = 1'b0, wd = 1'b0, ctlWe = 1'b0, ctlData = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, extWdata;
  logic        done, mis, flt, extReq, extWe, extWord;
  logic [23:0] extAddr;

  int total = 0, bad = 0;
  bit finished = 0;

  ram_window u_ram_window (
    .clk(clk), .rstN(rstN), .cpuReq(req), .cpuWe(we), .cpuWord(wd), .cpuAddr(addr),
    .cpuWdata(wdata), .ctlWe(ctlWe), .ctlData(ctlData), .cpuRdata(rdata),
    .cpuDone(done), .misalign(mis), .fault(flt), .extReq(extReq), .extWe(extWe),
    .extWord(extWord), .extAddr(extAddr), .extWdata(extWdata)
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [7:0]  refMem [int];
  logic        modelEn = 1'b1;
  logic        expDone = 0, expMis = 0, expFlt = 0, expRdValid = 0;
  logic [15:0] expRd = '0;
  string       rdTag = "R5";

  function automatic int regionOf(logic [23:0] a, logic en);
    if (!en) return 0;
    if (a >= BASE && a <= 24'hFFEFBF) return 1;
    if (a >= 24'hFFFFC0) return 2;
    if (a >= 24'hFFB000 && a < BASE) return 3;
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      modelEn = 1'b1; expDone = 0; expMis = 0; expFlt = 0; expRdValid = 0;
    end else begin
      int rg;
      int a0;
      rg = regionOf(addr, modelEn);
      a0 = int'(addr) & ~1;
      expDone = req && rg != 0;
      expMis = req && (rg == 1 || rg == 2) && wd && addr[0];
      expFlt = req && rg == 3;
      expRdValid = 0;
      if (req && !we && rg == 3) begin
        expRd = 16'hFFFF; expRdValid = 1; rdTag = "R10";
      end else if (req && !we && rg != 0) begin
        if (wd && refMem.exists(a0) && refMem.exists(a0 + 1)) begin
          expRd = {refMem[a0], refMem[a0 + 1]}; expRdValid = 1; rdTag = "R6";
        end else if (!wd && refMem.exists(int'(addr))) begin
          expRd = {8'h00, refMem[int'(addr)]}; expRdValid = 1; rdTag = "R8";
        end
      end
      if (req && we && (rg == 1 || rg == 2)) begin
        if (wd) begin refMem[a0] = wdata[15:8]; refMem[a0 + 1] = wdata[7:0]; end
        else refMem[int'(addr)] = wdata[7:0];
      end
      if (ctlWe) modelEn = ctlData;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      int rg;
      rg = regionOf(addr, modelEn);
      check("R5 done", done, expDone);
      check("R9 misalign", mis, expMis);
      check("R10/R11 fault", flt, expFlt);
      if (expRdValid) check({rdTag, " rdata"}, rdata, expRd);
      check(modelEn ? "R4 extReq" : "R3 extReq", extReq, req && rg == 0);
      if (req && rg == 0) begin
        check("R4 extAddr", extAddr, addr);
        check("R4 extWe", extWe, we);
        check("R4 extWord", extWord, wd);
        check("R4 extWdata", extWdata, wdata);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic op(logic w, logic word, logic [23:0] a, logic [15:0] d);
    @(posedge clk); #2;
    req = 1; we = w; wd = word; addr = a; wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    req = 0; we = 0; ctlWe = 0;
  endtask

  task automatic setEn(logic v);
    @(posedge clk); #2;
    req = 0; ctlWe = 1; ctlData = v;
  endtask

  // read and check data directly at the port
  task automatic readChk(logic word, logic [23:0] a, logic [15:0] exp, string tag);
    op(0, word, a, 16'h0);
    idle();
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  initial begin
    #(200000 * 10);
    check("watchdog", 1, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    @(negedge clk);
    // R12: reset state
    check("R12 reset done", done, 0);
    check("R12 reset fault", flt, 0);
    check("R12 reset misalign", mis, 0);

    // R1: main range, word writes at both ends
    op(1, 1, BASE, 16'hA1B2);
    op(1, 1, 24'hFFEFBE, 16'hC3D4);
    idle();
    readChk(1, BASE, 16'hA1B2, "R1/R6 base word");
    readChk(1, 24'hFFEFBE, 16'hC3D4, "R1/R6 last word");
    readChk(0, BASE, 16'h00A1, "R8 even byte");
    readChk(0, BASE + 1, 16'h00B2, "R8 odd byte");

    // R7: byte writes touch one lane only
    op(1, 0, BASE + 1, 16'hEE5A);
    idle();
    readChk(1, BASE, 16'hA15A, "R7 odd byte lane");
    op(1, 0, 24'hFFEFBE, 16'h1177);
    idle();
    readChk(1, 24'hFFEFBE, 16'h77D4, "R7 even byte lane");

    // R2: upper range, separate storage
    op(1, 1, 24'hFFFFC0, 16'h1234);
    op(1, 1, 24'hFFFFFE, 16'h5678);
    idle();
    readChk(1, 24'hFFFFC0, 16'h1234, "R2 top first");
    readChk(1, 24'hFFFFFE, 16'h5678, "R2 top last");
    readChk(1, BASE, 16'hA15A, "R2 main unaffected");

    // R9: odd word address is aligned down
    op(1, 1, BASE + 5, 16'hBEEF);
    idle();
    readChk(1, BASE + 4, 16'hBEEF, "R9 aligned write");
    readChk(1, BASE + 5, 16'hBEEF, "R9 aligned read");

    // R10/R11: blocked region
    readChk(1, 24'hFFB000, 16'hFFFF, "R10 blocked first");
    readChk(0, BASE - 1, 16'hFFFF, "R10 blocked last");
    op(1, 1, BASE - 2, 16'h0000);
    idle();
    readChk(1, BASE - 2, 16'hFFFF, "R11 blocked after write");
    readChk(1, BASE, 16'hA15A, "R11 ram unchanged");

    // R4: gaps always external
    op(1, 1, 24'hFFF000, 16'h4242);
    op(0, 0, 24'hFFAFFF, 16'h0);
    op(0, 1, 24'h000100, 16'h0);
    idle();

    // R12: control write applies next cycle; same-cycle access uses old value
    @(posedge clk); #2;
    ctlWe = 1; ctlData = 0; req = 1; we = 1; wd = 1; addr = BASE + 8; wdata = 16'h9999;
    @(posedge clk); #2;
    ctlWe = 0; req = 1; we = 1; wd = 1; addr = BASE; wdata = 16'h0000;
    @(negedge clk);
    check("R12 same-cycle access internal", done, 1);
    check("R12 new value in force", extReq, 1);
    // R3: all windows forwarded while disabled
    op(0, 1, 24'hFFFFC0, 16'h0);
    op(0, 1, 24'hFFB010, 16'h0);
    op(1, 0, BASE + 1, 16'h0033);
    idle();
    setEn(1);
    idle();
    readChk(1, BASE, 16'hA15A, "R3 forwarded write left ram");
    readChk(1, BASE + 8, 16'h9999, "R12 old-value write stored");

    repeat (3) idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule